// File: doc/BRIEF.md
# Burst Read Return Pipeline with Programmable Column Latency

This block models the read data path of a synchronous memory array. A column read command names a starting word. A programmable number of clock cycles after the command is taken, the array returns that word on the output. The rest of the burst follows on the next cycles, one word per cycle.

A burst holds 4 or 8 words, chosen for each command. The burst begins with the requested word, so a consumer can use that word before the burst ends. The burst then wraps inside the aligned block of words that holds the start column. A second read may be issued while an earlier one is still waiting out its latency. Well-timed commands therefore keep the output busy on every cycle. A command whose data would land on top of beats that are already scheduled is dropped, and an error strobe marks it.

The backing word array is filled through a plain write port. The latency setting is a register. It can be reloaded only while no read is outstanding, and the new value applies from the next command onward.

Top module: `cas_burst_reader`

## Requirements
- R1: After reset, `rd_valid` and `rd_err` are 0 and the latency setting is 3 cycles.
- R2: A read that is accepted at clock edge E shows its first beat with `rd_valid`=1 in the cycle that follows edge E+CL, where CL is the latency setting in force at edge E.
- R3: Each accepted read drives `rd_valid` high for one unbroken run of burst-length cycles. `rd_beat` counts 0, 1, … burst-length−1 across that run.
- R4: Beat i returns the word at address {start[COL_W-1:k], (start[k-1:0]+i) mod 2^k}, where k=2 for a 4-word burst and k=3 for an 8-word burst. The upper column bits stay fixed.
- R5: `rd_long`=1 at the command selects an 8-word burst, and `rd_long`=0 selects a 4-word burst.
- R6: A read is accepted when its first beat edge E+CL comes later than the last scheduled beat edge. Commands spaced exactly one burst apart therefore stream with no idle cycle.
- R7: A read whose first beat would fall on or before an already scheduled beat is dropped. It produces no beats, and `rd_err` is 1 for the single cycle after that edge.
- R8: `cl_load` writes `cl_value` into the latency setting only when no beat is scheduled and the value lies in 2..MAX_CL. Otherwise the setting does not change. A read taken on the same edge as a load uses the old setting.
- R9: Latencies up to MAX_CL (15 by default) are supported. A latency of 9 delays the first beat by 9 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cl_load | input | 1 | Request to load a new latency setting |
| cl_value | input | CL_W | Latency value in cycles |
| rd_req | input | 1 | Column read command |
| rd_col | input | COL_W | Start (critical) column |
| rd_long | input | 1 | 1 = 8-word burst, 0 = 4-word burst |
| wr_en | input | 1 | Write enable for the backing array |
| wr_addr | input | COL_W | Backing array write address |
| wr_data | input | DATA_W | Backing array write data |
| rd_data | output | DATA_W | Returned word |
| rd_valid | output | 1 | Returned word is valid |
| rd_beat | output | 3 | Index of the beat within its burst |
| rd_err | output | 1 | Previous-cycle read was rejected as overlapping |

## Verification
Some properties hold on every cycle, and the assertions check those. The beat index steps by one inside a valid run. A run ends only at beat 3 or beat 7. An error strobe is always caused by a request. The latency setting stays in range and stays frozen while beats are pending.

Other behaviour needs a reference model, so only the bench can show it. That covers the exact cycle of the first beat for each latency and the wrapped word order. It also covers the accept/reject boundary between overlapping and abutting commands, and whether a load is honoured or ignored. The bench compares every output cycle with a schedule it builds independently.

// File: rtl/cas_burst_reader.sv
module cas_burst_reader #(
  parameter int DATA_W   = 16,
  parameter int COL_W    = 6,
  parameter int MAX_CL   = 15,
  parameter int CL_RESET = 3,
  parameter int CL_W     = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cl_load,
  input  logic [CL_W-1:0]   cl_value,
  input  logic              rd_req,
  input  logic [COL_W-1:0]  rd_col,
  input  logic              rd_long,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [2:0]        rd_beat,
  output logic              rd_err
);
  localparam int DEPTH = 1 << COL_W;
  localparam int PW    = $clog2(MAX_CL + 9);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CL_W-1:0]   cl_q;
  logic [PW-1:0]     pend;
  logic [MAX_CL-1:0] slot_v;
  logic [COL_W-1:0]  slot_c [MAX_CL];
  logic [MAX_CL-1:0] slot_l;
  logic              act, long_q;
  logic [2:0]        beat;
  logic [COL_W-1:0]  base;

  wire [PW-1:0] cl_ext = PW'(cl_q);
  wire accept = rd_req && (cl_ext >= pend);
  wire cl_ok  = cl_load && (pend == '0) &&
                (cl_value >= CL_W'(2)) && (cl_value <= CL_W'(MAX_CL));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_q   <= CL_W'(CL_RESET);
      pend   <= '0;
      rd_err <= 1'b0;
    end else begin
      if (cl_ok) cl_q <= cl_value;
      if (accept)            pend <= cl_ext + (rd_long ? PW'(7) : PW'(3));
      else if (pend != '0)   pend <= pend - PW'(1);
      rd_err <= rd_req && !accept;
    end
  end

  for (genvar k = 0; k < MAX_CL; k++) begin : g_slot
    wire hit = accept && (CL_W'(k + 1) == cl_q);
    if (k == MAX_CL - 1) begin : g_top
      always_ff @(posedge clk) begin
        if (!rst_n) slot_v[k] <= 1'b0;
        else        slot_v[k] <= hit;
        if (hit) begin
          slot_c[k] <= rd_col;
          slot_l[k] <= rd_long;
        end
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (!rst_n) slot_v[k] <= 1'b0;
        else        slot_v[k] <= hit ? 1'b1 : slot_v[k+1];
        slot_c[k] <= hit ? rd_col  : slot_c[k+1];
        slot_l[k] <= hit ? rd_long : slot_l[k+1];
      end
    end
  end

  wire              start  = slot_v[0];
  wire              last   = beat == (long_q ? 3'd7 : 3'd3);
  wire              n_act  = start || (act && !last);
  wire [2:0]        n_beat = start ? 3'd0 : (act ? beat + 3'd1 : 3'd0);
  wire [COL_W-1:0]  n_base = start ? slot_c[0] : base;
  wire              n_long = start ? slot_l[0] : long_q;
  wire [COL_W-1:0]  mask   = n_long ? COL_W'(7) : COL_W'(3);
  wire [COL_W-1:0]  addr   = (n_base & ~mask) | ((n_base + COL_W'(n_beat)) & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= 1'b0;
      beat   <= 3'd0;
      long_q <= 1'b0;
    end else begin
      act    <= n_act;
      beat   <= n_beat;
      long_q <= n_long;
    end
    base    <= n_base;
    rd_data <= mem[addr];
  end

  assign rd_valid = act;
  assign rd_beat  = beat;
endmodule

module cas_burst_reader_chk #(
  parameter int MAX_CL = 15,
  parameter int CL_W   = 4,
  parameter int PW     = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic            rd_valid,
  input logic [2:0]      rd_beat,
  input logic            rd_err,
  input logic            long_q,
  input logic [CL_W-1:0] cl_q,
  input logic [PW-1:0]   pend
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !rd_valid && !rd_err);
  p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat != 3'd0) |-> ($past(rd_valid) && rd_beat == $past(rd_beat) + 3'd1));
  p_beat_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_beat <= (long_q ? 3'd7 : 3'd3));
  p_burst_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) && rd_beat == 3'd0) |->
      $past(rd_beat) == ($past(long_q) ? 3'd7 : 3'd3));
  p_valid_scheduled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(pend) != '0);
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(rd_req));
  p_cl_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_q >= CL_W'(2)) && (cl_q <= CL_W'(MAX_CL)));
  p_cl_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |=> $stable(cl_q));
endmodule

bind cas_burst_reader cas_burst_reader_chk #(.MAX_CL(MAX_CL), .CL_W(CL_W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_valid(rd_valid), .rd_beat(rd_beat),
  .rd_err(rd_err), .long_q(long_q), .cl_q(cl_q), .pend(pend)
);

// File: tb/test_cas_burst_reader.sv
`timescale 1ns/1ps
module test_cas_burst_reader;
  localparam int EXPN = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cl_load = 1'b0;
  logic [3:0] cl_value = '0;
  logic rd_req = 1'b0;
  logic [5:0] rd_col = '0;
  logic rd_long = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic rd_valid;
  logic [2:0] rd_beat;
  logic rd_err;

  always #2.5 clk = ~clk;

  cas_burst_reader i_cas_burst_reader (
    .clk(clk), .rst_n(rst_n), .cl_load(cl_load), .cl_value(cl_value),
    .rd_req(rd_req), .rd_col(rd_col), .rd_long(rd_long),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_beat(rd_beat), .rd_err(rd_err)
  );

  int errs = 0, checks = 0, n = 0, cl_m = 3, last_edge = -1;
  string phase = "R1";
  logic [15:0] mirror [64];
  bit exp_v [EXPN];
  bit exp_e [EXPN];
  logic [15:0] exp_d [EXPN];
  int exp_b [EXPN];

  function automatic logic [5:0] wrap_addr(input logic [5:0] col, input bit lng, input int i);
    logic [5:0] m;
    m = lng ? 6'd7 : 6'd3;
    return (col & ~m) | ((col + 6'(i)) & m);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL [%s] %s edge %0d: actual=%0h expected=%0h", phase, req, n, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    n++;
    @(negedge clk);
    if (n < EXPN) begin
      check("R2 valid", int'(rd_valid), int'(exp_v[n]));
      check("R7 err", int'(rd_err), int'(exp_e[n]));
      if (exp_v[n]) begin
        check("R3 beat", int'(rd_beat), exp_b[n]);
        check("R4 data", int'(rd_data), int'(exp_d[n]));
      end
    end
  endtask

  task automatic cmd(input bit req, input logic [5:0] col, input bit lng,
                     input bit ld, input logic [3:0] clv);
    int e, bl;
    bit idle;
    e = n + 1;
    idle = last_edge < e;
    rd_req = req; rd_col = col; rd_long = lng; cl_load = ld; cl_value = clv;
    if (req) begin
      bl = lng ? 8 : 4;
      if (e + cl_m > last_edge) begin
        for (int i = 0; i < bl; i++) begin
          if (e + cl_m + i < EXPN) begin
            exp_v[e + cl_m + i] = 1'b1;
            exp_b[e + cl_m + i] = i;
            exp_d[e + cl_m + i] = mirror[wrap_addr(col, lng, i)];
          end
        end
        last_edge = e + cl_m + bl - 1;
      end else if (e < EXPN) begin
        exp_e[e] = 1'b1;
      end
    end
    if (ld && idle && clv >= 4'd2 && clv <= 4'd15) cl_m = int'(clv);
    tick();
    rd_req = 1'b0; cl_load = 1'b0;
  endtask

  task automatic idle_for(input int k);
    for (int i = 0; i < k; i++) cmd(1'b0, 6'd0, 1'b0, 1'b0, 4'd0);
  endtask

  initial begin
    for (int i = 0; i < EXPN; i++) begin
      exp_v[i] = 1'b0; exp_e[i] = 1'b0; exp_d[i] = '0; exp_b[i] = 0;
    end
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      mirror[i] = 16'($urandom());
      wr_en = 1'b1; wr_addr = 6'(i); wr_data = mirror[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    phase = "R1 reset";
    idle_for(2);

    phase = "R1 default latency R2 R4";
    cmd(1'b1, 6'd5, 1'b0, 1'b0, 4'd0);
    idle_for(10);

    phase = "R8 load R5 long burst";
    cmd(1'b0, 6'd0, 1'b0, 1'b1, 4'd2);
    cmd(1'b1, 6'd13, 1'b1, 1'b0, 4'd0);
    idle_for(12);

    phase = "R8 load while busy ignored";
    cmd(1'b1, 6'd40, 1'b0, 1'b0, 4'd0);
    cmd(1'b0, 6'd0, 1'b0, 1'b1, 4'd9);
    idle_for(8);
    cmd(1'b1, 6'd22, 1'b0, 1'b0, 4'd0);
    idle_for(8);

    phase = "R8 out of range ignored";
    cmd(1'b0, 6'd0, 1'b0, 1'b1, 4'd1);
    cmd(1'b0, 6'd0, 1'b0, 1'b1, 4'd0);
    cmd(1'b1, 6'd31, 1'b1, 1'b0, 4'd0);
    idle_for(12);

    phase = "R9 latency nine";
    cmd(1'b0, 6'd0, 1'b0, 1'b1, 4'd9);
    cmd(1'b1, 6'd62, 1'b1, 1'b0, 4'd0);
    idle_for(20);

    phase = "R8 same edge load and read";
    cmd(1'b1, 6'd9, 1'b0, 1'b1, 4'd4);
    idle_for(16);
    cmd(1'b1, 6'd10, 1'b0, 1'b0, 4'd0);
    idle_for(10);

    phase = "R6 streaming";
    cmd(1'b0, 6'd0, 1'b0, 1'b1, 4'd2);
    for (int j = 0; j < 6; j++) begin
      cmd(1'b1, 6'(j * 7), 1'b0, 1'b0, 4'd0);
      idle_for(3);
    end
    for (int j = 0; j < 4; j++) begin
      cmd(1'b1, 6'(j * 11 + 3), 1'b1, 1'b0, 4'd0);
      idle_for(7);
    end
    idle_for(10);

    phase = "R7 overlap rejected";
    cmd(1'b1, 6'd17, 1'b1, 1'b0, 4'd0);
    cmd(1'b1, 6'd18, 1'b0, 1'b0, 4'd0);
    idle_for(5);
    cmd(1'b1, 6'd19, 1'b0, 1'b0, 4'd0);
    idle_for(12);

    phase = "R2 R3 R4 R6 R7 R8 random";
    for (int j = 0; j < 3000; j++) begin
      cmd(($urandom() % 100) < 35, 6'($urandom()), 1'($urandom()),
          ($urandom() % 100) < 6, 4'($urandom()));
    end
    idle_for(30);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errs++;
    checks++;
    $display("FAIL [watchdog] run did not finish: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule